// File: doc/BRIEF.md
# Microcoded Peripheral Bring-Up Sequencer

After power-on, this block brings up an external peripheral by running a short program held in a constant on-chip ROM. The program is the module parameter `PROGRAM`. Each word is read in a fetch cycle. It is then decoded in one idle cycle and executed. One opcode holds the peripheral reset line high for a programmed number of clock cycles. A second opcode passes an address/data pair to a separate bus-write engine and waits for that engine to report completion. A third opcode ends the program. When the current instruction finishes, the program counter moves to the next word.

Changing which peripheral registers are written, or how long the reset is held, only needs a new `PROGRAM` image. The state machine stays the same. The default image holds reset for 1,600,000 cycles (20 ms at 80 MHz), then performs ten register writes, then stops.

Top module: `periph_boot_seq`

Word layout (28 bits): opcode in bits [27:26], register address in bits [25:16], data in bits [15:0]. The reset opcode reads bits [25:0] as one cycle count. Word 0 sits in the least significant bits of `PROGRAM`.

States: `ST_FETCH`, `ST_DECODE`, `ST_RST_HOLD`, `ST_WR_ISSUE`, `ST_WR_WAIT`, `ST_HALT`.

Transitions:
- FETCH→DECODE when the counter is inside the ROM; FETCH→HALT when it has run past the last word.
- DECODE→RST_HOLD on opcode 00.
- DECODE→WR_ISSUE on opcode 01.
- DECODE→HALT on opcode 10 or 11.
- RST_HOLD→FETCH when the hold count is used up.
- WR_ISSUE→WR_WAIT always.
- WR_WAIT→FETCH on `wr_done`.
- HALT stays in HALT until reset.

## Requirements
- R1: While `rst_n` is low, `periph_rst`, `wr_start` and `boot_done` are all low.
- R2: The first instruction (word 0) takes effect at the second rising edge after `rst_n` is released (one fetch cycle, one decode cycle). Instructions then run strictly in ROM order, each after the previous one has completed.
- R3: Opcode 00 raises `periph_rst` for exactly N consecutive cycles, where N is the unsigned count in bits [25:0].
- R4: Opcode 01 raises `wr_start` for exactly one cycle. During that cycle `wr_addr` carries bits [25:16] of the word and `wr_data` carries bits [15:0].
- R5: After a write starts, the sequencer waits for `wr_done` for as long as the engine needs. While it waits, `wr_addr` and `wr_data` hold steady and no other activity begins.
- R6: Opcode 00 with a count of zero holds `periph_rst` for exactly one cycle.
- R7: Opcode 10 raises `boot_done`. `boot_done` then stays high until reset, and no further `wr_start` or `periph_rst` appears.
- R8: `wr_done` is honoured only in the write-wait state. A pulse during a reset hold, in the start cycle, or after halt has no effect.
- R9: If the program counter runs past the last ROM word with no stop opcode, the sequencer halts with `boot_done` high.
- R10: The unused opcode 11 halts the sequencer like a stop: `boot_done` rises and no later word runs.
- R11: `periph_rst` and `wr_start` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the program from word 0 |
| wr_done | input | 1 | Completion pulse from the bus-write engine |
| periph_rst | output | 1 | Reset line to the peripheral, active high |
| wr_start | output | 1 | One-cycle request to the bus-write engine |
| wr_addr | output | ADDR_W (10) | Register address for the requested write |
| wr_data | output | DATA_W (16) | Data for the requested write |
| boot_done | output | 1 | High once the program has halted |

## Verification
Three programs are run:
- **Full program.** Mixes non-zero and zero reset counts with writes that the modelled engine answers after one, three and six cycles. This separates a sequencer that really waits for completion from one that moves on after a fixed delay. The extreme address and data values `0x3FF` and `0xFFFF` would expose a field taken from the wrong bits.
- **Program with no stop.** Shows whether the end-of-ROM guard halts the sequencer.
- **Program containing the unused opcode.** Shows whether an undefined word is treated as a stop rather than being skipped.

In addition, `wr_done` pulses are injected during a reset hold and after halt. Any change in the reset width or the halted state would show that completion is honoured outside the write-wait state.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int OP_W     = 2;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 16;
    localparam int CNT_W    = ADDR_W + DATA_W;
    localparam int WORD_W   = OP_W + CNT_W;
    localparam int DEF_DEPTH = 16;

    typedef enum logic [OP_W-1:0] {
        OPC_HOLD_RST = 2'b00,
        OPC_WRITE    = 2'b01,
        OPC_STOP     = 2'b10,
        OPC_RSVD     = 2'b11
    } boot_op_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_RST_HOLD,
        ST_WR_ISSUE,
        ST_WR_WAIT,
        ST_HALT
    } boot_state_e;

    function automatic logic [WORD_W-1:0] mk_hold(input logic [CNT_W-1:0] cycles);
        return {OPC_HOLD_RST, cycles};
    endfunction

    function automatic logic [WORD_W-1:0] mk_write(input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
        return {OPC_WRITE, a, d};
    endfunction

    function automatic logic [WORD_W-1:0] mk_stop();
        return {OPC_STOP, {CNT_W{1'b0}}};
    endfunction

    // Default image: 20 ms hold at 80 MHz, ten register writes, then stop.
    function automatic logic [DEF_DEPTH*WORD_W-1:0] default_image();
        logic [DEF_DEPTH*WORD_W-1:0] img;
        img = '0;
        for (int i = 0; i < DEF_DEPTH; i++) begin
            if (i == 0)
                img[i*WORD_W +: WORD_W] = mk_hold(CNT_W'(1_600_000));
            else if (i <= 10)
                img[i*WORD_W +: WORD_W] = mk_write(ADDR_W'(i), DATA_W'(16'h1000 + i));
            else
                img[i*WORD_W +: WORD_W] = mk_stop();
        end
        return img;
    endfunction

endpackage

// File: rtl/boot_rom.sv
module boot_rom #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 28,
    parameter int PC_W   = 5,
    parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
    input  logic [PC_W-1:0]   addr,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] cells [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            assign cells[i] = IMAGE[i*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == PC_W'(i))
                word = cells[i];
        end
    end

endmodule

// File: rtl/boot_pc.sv
module boot_pc #(
    parameter int DEPTH = 16,
    parameter int PC_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    output logic [PC_W-1:0] pc,
    output logic            at_end
);

    localparam logic [PC_W-1:0] END_PC = PC_W'(DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc <= '0;
        else if (inc && !at_end)
            pc <= pc + 1'b1;
    end

    assign at_end = (pc == END_PC);

endmodule

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (load_val == '0) ? CNT_W'(1) : load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int CNT_W  = ADDR_W + DATA_W,
    parameter int WORD_W = 2 + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rom_word,
    input  logic              at_end,
    input  logic              tmr_last,
    input  logic              wr_done,
    output logic              pc_inc,
    output logic              tmr_load,
    output logic              tmr_dec,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              periph_rst,
    output logic              wr_start,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              boot_done
);

    boot_state_e       state, state_nx;
    logic [WORD_W-1:0] ir;
    boot_op_e          op;

    assign op = boot_op_e'(ir[WORD_W-1 -: 2]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_FETCH;
        else
            state <= state_nx;
    end

    // Instruction register, captured in the fetch cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ir <= '0;
        else if (state == ST_FETCH && !at_end)
            ir <= rom_word;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:    state_nx = at_end ? ST_HALT : ST_DECODE;
            ST_DECODE: begin
                unique case (op)
                    OPC_HOLD_RST: state_nx = ST_RST_HOLD;
                    OPC_WRITE:    state_nx = ST_WR_ISSUE;
                    OPC_STOP,
                    OPC_RSVD:     state_nx = ST_HALT;
                endcase
            end
            ST_RST_HOLD: if (tmr_last) state_nx = ST_FETCH;
            ST_WR_ISSUE: state_nx = ST_WR_WAIT;
            ST_WR_WAIT:  if (wr_done) state_nx = ST_FETCH;
            ST_HALT:     state_nx = ST_HALT;
            default:     state_nx = ST_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        pc_inc     = 1'b0;
        tmr_load   = 1'b0;
        tmr_dec    = 1'b0;
        periph_rst = 1'b0;
        wr_start   = 1'b0;
        boot_done  = 1'b0;
        unique case (state)
            ST_FETCH:    ;
            ST_DECODE:   tmr_load = (op == OPC_HOLD_RST);
            ST_RST_HOLD: begin
                periph_rst = 1'b1;
                tmr_dec    = !tmr_last;
                pc_inc     = tmr_last;
            end
            ST_WR_ISSUE: wr_start = 1'b1;
            ST_WR_WAIT:  pc_inc = wr_done;
            ST_HALT:     boot_done = 1'b1;
            default:     boot_done = 1'b1;
        endcase
    end

    assign tmr_val = ir[CNT_W-1:0];
    assign wr_addr = ir[CNT_W-1 -: ADDR_W];
    assign wr_data = ir[DATA_W-1:0];

endmodule

// File: rtl/periph_boot_seq.sv
module periph_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int DEPTH  = boot_seq_pkg::DEF_DEPTH,
    parameter int ADDR_W = boot_seq_pkg::ADDR_W,
    parameter int DATA_W = boot_seq_pkg::DATA_W,
    parameter logic [DEPTH*(2+ADDR_W+DATA_W)-1:0] PROGRAM = boot_seq_pkg::default_image()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    output logic              periph_rst,
    output logic              wr_start,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              boot_done
);

    localparam int CNT_W  = ADDR_W + DATA_W;
    localparam int WORD_W = 2 + CNT_W;
    localparam int PC_W   = $clog2(DEPTH + 1);

    logic [PC_W-1:0]   pc;
    logic              at_end;
    logic              pc_inc;
    logic [WORD_W-1:0] rom_word;
    logic              tmr_load, tmr_dec, tmr_last;
    logic [CNT_W-1:0]  tmr_val;

    boot_rom #(
        .DEPTH (DEPTH),
        .WORD_W(WORD_W),
        .PC_W  (PC_W),
        .IMAGE (PROGRAM)
    ) u_rom (
        .addr(pc),
        .word(rom_word)
    );

    boot_pc #(
        .DEPTH(DEPTH),
        .PC_W (PC_W)
    ) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pc_inc),
        .pc    (pc),
        .at_end(at_end)
    );

    boot_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .dec     (tmr_dec),
        .last    (tmr_last)
    );

    boot_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W),
        .WORD_W(WORD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rom_word  (rom_word),
        .at_end    (at_end),
        .tmr_last  (tmr_last),
        .wr_done   (wr_done),
        .pc_inc    (pc_inc),
        .tmr_load  (tmr_load),
        .tmr_dec   (tmr_dec),
        .tmr_val   (tmr_val),
        .periph_rst(periph_rst),
        .wr_start  (wr_start),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .boot_done (boot_done)
    );

endmodule

// File: rtl/periph_boot_seq_chk.sv
module periph_boot_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_done,
    input logic              periph_rst,
    input logic              wr_start,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              boot_done
);

    // R4: write request lasts one cycle
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);

    // R5: fields hold steady into the wait
    a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> ($stable(wr_addr) && $stable(wr_data)));

    // R7: halt is sticky
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);

    // R7: nothing happens once halted
    a_r7_quiet_halt: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> (!wr_start && !periph_rst));

    // R11: reset hold and write request are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_start && periph_rst));

endmodule

bind periph_boot_seq periph_boot_seq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_done   (wr_done),
    .periph_rst(periph_rst),
    .wr_start  (wr_start),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .boot_done (boot_done)
);

// File: tb/tb_periph_boot_seq.sv
module tb_periph_boot_seq;
    import boot_seq_pkg::*;

    localparam time CLK_P = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_drv = 1'b0;
    int   sel = 0;
    int   tests = 0;
    int   fails = 0;
    int   overlap = 0;

    always #(CLK_P/2) clk = ~clk;

    // Program A: hold 5, write, hold 0, write, write, stop, write (dead), hold 4 (dead)
    localparam logic [8*WORD_W-1:0] PROG_A = {
        mk_hold(26'd4),
        mk_write(10'h155, 16'h1234),
        mk_stop(),
        mk_write(10'h200, 16'hFFFF),
        mk_write(10'h3FF, 16'h0001),
        mk_hold(26'd0),
        mk_write(10'h012, 16'hA5A5),
        mk_hold(26'd5)
    };
    // Program B: no stop, runs off the end
    localparam logic [3*WORD_W-1:0] PROG_B = {
        mk_hold(26'd3),
        mk_write(10'h022, 16'h0F0F),
        mk_write(10'h021, 16'hBEEF)
    };
    // Program C: unused opcode 11 after one write
    localparam logic [3*WORD_W-1:0] PROG_C = {
        mk_write(10'h0BB, 16'h7777),
        {2'b11, 26'h0},
        mk_write(10'h0AA, 16'h5555)
    };

    logic        rst_o [3];
    logic        st_o  [3];
    logic        dn_o  [3];
    logic [9:0]  ad_o  [3];
    logic [15:0] da_o  [3];
    logic        d0, d1, d2;

    assign d0 = done_drv && (sel == 0);
    assign d1 = done_drv && (sel == 1);
    assign d2 = done_drv && (sel == 2);

    periph_boot_seq #(.DEPTH(8), .PROGRAM(PROG_A)) dut (
        .clk(clk), .rst_n(rst_n), .wr_done(d0), .periph_rst(rst_o[0]),
        .wr_start(st_o[0]), .wr_addr(ad_o[0]), .wr_data(da_o[0]), .boot_done(dn_o[0]));
    periph_boot_seq #(.DEPTH(3), .PROGRAM(PROG_B)) dut_b (
        .clk(clk), .rst_n(rst_n), .wr_done(d1), .periph_rst(rst_o[1]),
        .wr_start(st_o[1]), .wr_addr(ad_o[1]), .wr_data(da_o[1]), .boot_done(dn_o[1]));
    periph_boot_seq #(.DEPTH(3), .PROGRAM(PROG_C)) dut_c (
        .clk(clk), .rst_n(rst_n), .wr_done(d2), .periph_rst(rst_o[2]),
        .wr_start(st_o[2]), .wr_addr(ad_o[2]), .wr_data(da_o[2]), .boot_done(dn_o[2]));

    logic        o_rst, o_st, o_dn;
    logic [9:0]  o_ad;
    logic [15:0] o_da;

    always_comb begin
        o_rst = rst_o[sel];
        o_st  = st_o[sel];
        o_dn  = dn_o[sel];
        o_ad  = ad_o[sel];
        o_da  = da_o[sel];
    end

    // R11 monitor over all instances
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++)
            if (rst_n && rst_o[i] && st_o[i]) overlap++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        done_drv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rst(input string req, input int lim);
        int n = 0;
        while (!o_rst && n < lim) begin @(negedge clk); n++; end
        check(o_rst, req, "reset hold never began", 32'(o_rst), 1);
    endtask

    task automatic pulse_width(input int inj, output int w);
        w = 0;
        while (o_rst && w < 100) begin
            w++;
            done_drv = (w == inj);
            @(negedge clk);
        end
        done_drv = 1'b0;
    endtask

    task automatic serve_write(input logic [9:0] ea, input logic [15:0] ed,
                               input int delay, input string req);
        int n = 0;
        logic [9:0]  a0;
        logic [15:0] d0v;
        bit extra = 0;
        while (!o_st && n < 30) begin @(negedge clk); n++; end
        check(o_st, req, "write request never seen", 32'(o_st), 1);
        check(o_ad == ea, req, "write address", 32'(o_ad), 32'(ea));
        check(o_da == ed, req, "write data", 32'(o_da), 32'(ed));
        a0 = o_ad; d0v = o_da;
        for (int i = 1; i <= delay; i++) begin
            @(negedge clk);
            if (i == 1) check(!o_st, "R4", "start longer than one cycle", 32'(o_st), 0);
            if (o_st || o_rst) extra = 1;
        end
        // R5: waits for the engine, fields held
        check(!extra, "R5", "activity before done", 32'(extra), 0);
        check(o_ad == a0 && o_da == d0v, "R5", "fields moved while waiting",
              {6'b0, o_ad, o_da}, {6'b0, a0, d0v});
        done_drv = 1'b1;
        @(negedge clk);
        done_drv = 1'b0;
    endtask

    task automatic watch_quiet(input string req, input int cycles);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            done_drv = (i == 5);
            @(negedge clk);
            if (o_st || o_rst || !o_dn) bad++;
        end
        done_drv = 1'b0;
        check(bad == 0, req, "activity or done drop after halt", 32'(bad), 0);
    endtask

    task automatic wait_done(input string req, input int lim);
        int n = 0;
        while (!o_dn && n < lim) begin @(negedge clk); n++; end
        check(o_dn, req, "boot_done not raised", 32'(o_dn), 1);
    endtask

    task automatic t_reset_values();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check(!rst_o[i], "R1", "periph_rst in reset", 32'(rst_o[i]), 0);
            check(!st_o[i],  "R1", "wr_start in reset",   32'(st_o[i]), 0);
            check(!dn_o[i],  "R1", "boot_done in reset",  32'(dn_o[i]), 0);
        end
    endtask

    task automatic t_main_program();
        int w;
        sel = 0;
        do_reset();
        @(negedge clk);
        check(!o_rst, "R2", "hold active after one edge", 32'(o_rst), 0);
        @(negedge clk);
        check(o_rst, "R2", "hold not active after two edges", 32'(o_rst), 1);
        // R3 width, with a stray done (R8) injected mid-hold
        pulse_width(2, w);
        check(w == 5, "R3", "hold width of count 5 (R8 stray done)", 32'(w), 5);
        serve_write(10'h012, 16'hA5A5, 6, "R4");
        wait_rst("R6", 10);
        pulse_width(0, w);
        check(w == 1, "R6", "hold width of count 0", 32'(w), 1);
        // R2 order: next two writes in ROM order, with different engine delays
        serve_write(10'h3FF, 16'h0001, 1, "R2");
        serve_write(10'h200, 16'hFFFF, 3, "R2");
        wait_done("R7", 10);
        watch_quiet("R7", 40);
        check(o_dn, "R8", "done pulse after halt changed state", 32'(o_dn), 1);
    endtask

    task automatic t_runoff();
        int w;
        sel = 1;
        do_reset();
        serve_write(10'h021, 16'hBEEF, 2, "R9");
        serve_write(10'h022, 16'h0F0F, 1, "R9");
        wait_rst("R3", 10);
        pulse_width(0, w);
        check(w == 3, "R3", "hold width of count 3", 32'(w), 3);
        wait_done("R9", 6);
        watch_quiet("R9", 20);
    endtask

    task automatic t_reserved_op();
        sel = 2;
        do_reset();
        serve_write(10'h0AA, 16'h5555, 2, "R10");
        wait_done("R10", 6);
        watch_quiet("R10", 20);
    endtask

    initial begin
        #(CLK_P * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset_values();
        t_main_program();
        t_runoff();
        t_reserved_op();
        check(overlap == 0, "R11", "hold and request overlapped", 32'(overlap), 0);
        summary();
        $finish;
    end

endmodule